// File: doc/BRIEF.md
# Errored Packet Insertion Controller

This block chooses which outgoing packets the transmit path corrupts on purpose, for link and error-counter testing. The transmit path raises a one-cycle packet-start strobe at every packet boundary. In that same cycle the block answers with a corrupt flag that tells the datapath whether to damage that packet. The corruption itself happens elsewhere.

Automatic insertion is set by a 7-bit rate code and an 8-bit count. The rate code is a 4-bit mantissa times a power of ten, and its exponent is clamped at a parameterised maximum. The count sets how many automatic errors a run produces, and one reserved value makes the run endless. A start pulse arms a run. A finite run raises a sticky completion flag, which can drive an interrupt. A separate manual path turns each enabled rising edge of a request pin into one extra errored packet. The manual path adds to any automatic insertion and never replaces it.

Top module: `epi_ctrl`

## Requirements
- R1: The rate code holds a mantissa x in bits [3:0] and an exponent y in bits [6:4]. During a run, errored packets are the x·10^y-th, 2·x·10^y-th, and so on, counting packet strobes after the start pulse. Code 01h errors every packet, 0Fh every 15th and 11h every 10th.
- R2: A mantissa of zero, whatever the exponent, stops any run in progress and clears its packet position. No automatic error follows until a new start pulse is given with a nonzero mantissa.
- R3: Exponent codes above EXP_MAX (default 6) behave as EXP_MAX. With EXP_MAX=1, codes 72h and 62h both error every 20th packet.
- R4: A start pulse with a nonzero mantissa begins a run from packet position zero. This holds even when a run is already active.
- R5: A count of FFh makes the run continuous. Any other count N ends the run after N automatic errors. A count of 0 ends the run at once with no error.
- R6: The end of a finite run sets a sticky completion flag. A clear pulse resets the flag, and a set in the same cycle as a clear wins.
- R7: The interrupt output is high exactly when the completion flag and the interrupt enable are both 1.
- R8: While the manual enable is 1, a rising edge on the manual request is held until the next packet strobe in a later cycle. That packet is errored, once, however many edges came before it. While the enable is 0, edges are ignored.
- R9: Manual errors do not move the automatic packet position or use up the count. A manual request and an automatic hit on the same packet give a single corrupt flag.
- R10: The corrupt flag is high only in a cycle in which the packet strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_start_i | input | 1 | One-cycle strobe at each packet boundary |
| rate_i | input | 7 | Rate code: mantissa [3:0], exponent [6:4] |
| count_i | input | 8 | Errors per run; FFh means continuous |
| start_i | input | 1 | Start pulse arming an automatic run |
| man_en_i | input | 1 | Manual insertion enable |
| man_req_i | input | 1 | Manual request; rising edge requests one error |
| done_clr_i | input | 1 | Clears the completion flag |
| irq_en_i | input | 1 | Completion interrupt enable |
| corrupt_o | output | 1 | Corrupt the packet strobed in this cycle |
| done_o | output | 1 | Sticky completion flag |
| irq_o | output | 1 | Completion interrupt |

## Verification
The bound checker watches several rules on every cycle. The corrupt flag never appears without a strobe. A zero mantissa leaves no run active one cycle later. The completion flag holds until cleared, and it never rises while a continuous run is armed. A disabled manual path never gains a pending request, and the interrupt stays low while the flag is low. The exact spacing of errored packets for each rate code, the stop after N errors, the clamped exponent, and the fact that manual errors leave the automatic schedule unchanged all depend on packet counts over many cycles. Only the bench's sweeps of rate codes and scripted manual sequences can show those.

// File: rtl/epi_pkg.sv
`timescale 1ns/1ps
package epi_pkg;

   // 10 to the power k as a 64-bit constant.
   function automatic longint unsigned pow10(input int k);
      longint unsigned v;
      v = 1;
      for (int i = 0; i < k; i++) v = v * 10;
      return v;
   endfunction

   // Bits needed to hold value v (at least one).
   function automatic int bits_for(input longint unsigned v);
      int n;
      n = 1;
      for (int b = 0; b < 64; b++)
         if ((v >> b) != 0) n = b + 1;
      return n;
   endfunction

   // Width of the packet-position counter for the largest period.
   function automatic int per_bits(input int mant_w, input int exp_max);
      longint unsigned top;
      top = ((64'd1 << mant_w) - 64'd1) * pow10(exp_max);
      return bits_for(top);
   endfunction

endpackage

// File: rtl/epi_rate_dec.sv
`timescale 1ns/1ps
// Turns the mantissa/exponent rate code into a period in packets.
module epi_rate_dec #(
   parameter int MANT_W  = 4,
   parameter int EXP_W   = 3,
   parameter int EXP_MAX = 6,
   parameter int PER_W   = 24
) (
   input  logic [MANT_W+EXP_W-1:0] rate_i,
   output logic [PER_W-1:0]        period_o,
   output logic                    mant_zero_o
);
   localparam int N_EXP = 1 << EXP_W;

   if (EXP_MAX >= N_EXP) begin : g_bad_exp
      $error("epi_rate_dec: EXP_MAX does not fit the exponent field");
   end
   if (PER_W < epi_pkg::per_bits(MANT_W, EXP_MAX)) begin : g_bad_per
      $error("epi_rate_dec: PER_W too narrow for the largest period");
   end

   logic [MANT_W-1:0] mant;
   logic [EXP_W-1:0]  expo;
   logic [PER_W-1:0]  cand [N_EXP];

   assign mant = rate_i[MANT_W-1:0];
   assign expo = rate_i[MANT_W+EXP_W-1:MANT_W];

   // One constant-scaled product per exponent code; codes past the
   // maximum reuse the largest scale.
   for (genvar e = 0; e < N_EXP; e++) begin : g_exp
      localparam int ES = (e > EXP_MAX) ? EXP_MAX : e;
      localparam logic [PER_W-1:0] SCALE = PER_W'(epi_pkg::pow10(ES));
      assign cand[e] = PER_W'(mant) * SCALE;
   end

   assign period_o    = cand[expo];
   assign mant_zero_o = (mant == '0);
endmodule

// File: rtl/epi_auto_sched.sv
`timescale 1ns/1ps
// Automatic run: packet position counter plus remaining-error counter.
module epi_auto_sched #(
   parameter int PER_W = 24,
   parameter int CNT_W = 8,
   parameter logic [CNT_W-1:0] CONT_CODE = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pkt_start_i,
   input  logic             start_i,
   input  logic             mant_zero_i,
   input  logic [PER_W-1:0] period_i,
   input  logic [CNT_W-1:0] count_i,
   output logic             hit_o,
   output logic             done_evt_o,
   output logic             run_o,
   output logic             cont_o
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("epi_auto_sched: CNT_W must be at least 2");
   end

   logic             run_q;
   logic             cont_q;
   logic [PER_W-1:0] pos_q;
   logic [CNT_W-1:0] left_q;
   logic             at_mark;
   logic             last_hit;
   logic             start_ok;

   // The >= compare also covers a period lowered while a run is active.
   assign at_mark    = (pos_q >= (period_i - PER_W'(1)));
   assign hit_o      = run_q & pkt_start_i & ~mant_zero_i & at_mark;
   assign last_hit   = hit_o & ~cont_q & (left_q == CNT_W'(1));
   assign start_ok   = start_i & ~mant_zero_i;
   assign done_evt_o = last_hit | (start_ok & (count_i == '0));
   assign run_o      = run_q;
   assign cont_o     = cont_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         cont_q <= 1'b0;
         pos_q  <= '0;
         left_q <= '0;
      end else if (mant_zero_i) begin
         run_q  <= 1'b0;
         cont_q <= 1'b0;
         pos_q  <= '0;
         left_q <= '0;
      end else if (start_i) begin
         run_q  <= (count_i != '0);
         cont_q <= (count_i == CONT_CODE);
         pos_q  <= '0;
         left_q <= count_i;
      end else if (hit_o) begin
         pos_q <= '0;
         if (!cont_q) left_q <= left_q - CNT_W'(1);
         if (last_hit) run_q <= 1'b0;
      end else if (run_q && pkt_start_i) begin
         pos_q <= pos_q + PER_W'(1);
      end
   end
endmodule

// File: rtl/epi_man_latch.sv
`timescale 1ns/1ps
// Manual path: rising-edge detect, held until the next packet strobe.
module epi_man_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic req_i,
   input  logic pkt_start_i,
   output logic pend_o
);
   logic req_q;
   logic pend_q;
   logic rise;

   assign rise   = en_i & req_i & ~req_q;
   assign pend_o = pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         req_q <= req_i;
         // An edge in the strobe cycle itself belongs to the next packet.
         if (pkt_start_i)  pend_q <= rise;
         else if (rise)    pend_q <= 1'b1;
      end
   end
endmodule

// File: rtl/epi_ctrl.sv
`timescale 1ns/1ps
module epi_ctrl #(
   parameter int MANT_W  = 4,
   parameter int EXP_W   = 3,
   parameter int EXP_MAX = 6,
   parameter int CNT_W   = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    pkt_start_i,
   input  logic [MANT_W+EXP_W-1:0] rate_i,
   input  logic [CNT_W-1:0]        count_i,
   input  logic                    start_i,
   input  logic                    man_en_i,
   input  logic                    man_req_i,
   input  logic                    done_clr_i,
   input  logic                    irq_en_i,
   output logic                    corrupt_o,
   output logic                    done_o,
   output logic                    irq_o
);
   localparam int PER_W = epi_pkg::per_bits(MANT_W, EXP_MAX);
   localparam logic [CNT_W-1:0] CONT_CODE = '1;

   if (MANT_W < 1 || EXP_W < 1) begin : g_bad_fields
      $error("epi_ctrl: rate fields must be at least one bit");
   end

   logic [PER_W-1:0] period;
   logic             rate_off;
   logic             auto_hit;
   logic             done_evt;
   logic             run_active;
   logic             run_cont;
   logic             man_pend;
   logic             done_q;

   epi_rate_dec #(
      .MANT_W (MANT_W),
      .EXP_W  (EXP_W),
      .EXP_MAX(EXP_MAX),
      .PER_W  (PER_W)
   ) u_rate (
      .rate_i     (rate_i),
      .period_o   (period),
      .mant_zero_o(rate_off)
   );

   epi_auto_sched #(
      .PER_W    (PER_W),
      .CNT_W    (CNT_W),
      .CONT_CODE(CONT_CODE)
   ) u_auto (
      .clk        (clk),
      .rst_n      (rst_n),
      .pkt_start_i(pkt_start_i),
      .start_i    (start_i),
      .mant_zero_i(rate_off),
      .period_i   (period),
      .count_i    (count_i),
      .hit_o      (auto_hit),
      .done_evt_o (done_evt),
      .run_o      (run_active),
      .cont_o     (run_cont)
   );

   epi_man_latch u_man (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (man_en_i),
      .req_i      (man_req_i),
      .pkt_start_i(pkt_start_i),
      .pend_o     (man_pend)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)          done_q <= 1'b0;
      else if (done_evt)   done_q <= 1'b1;
      else if (done_clr_i) done_q <= 1'b0;
   end

   assign corrupt_o = pkt_start_i & (auto_hit | man_pend);
   assign done_o    = done_q;
   assign irq_o     = done_q & irq_en_i;
endmodule

// File: rtl/epi_ctrl_chk.sv
`timescale 1ns/1ps
module epi_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic pkt_start,
   input logic corrupt,
   input logic done,
   input logic done_clr,
   input logic irq,
   input logic man_en,
   input logic pend,
   input logic run,
   input logic cont,
   input logic rate_off
);
   assert_corrupt_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      corrupt |-> pkt_start);

   assert_zero_mant_stops_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rate_off |=> !run);

   assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !done_clr) |=> done);

   assert_done_not_cont_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> !cont);

   assert_irq_needs_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> !irq);

   assert_manual_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!man_en && !pend) |=> !pend);

   assert_pend_consumed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_start && pend && !man_en) |=> !pend);
endmodule

bind epi_ctrl epi_ctrl_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pkt_start(pkt_start_i),
   .corrupt  (corrupt_o),
   .done     (done_o),
   .done_clr (done_clr_i),
   .irq      (irq_o),
   .man_en   (man_en_i),
   .pend     (man_pend),
   .run      (run_active),
   .cont     (run_cont),
   .rate_off (rate_off)
);

// File: tb/tb_epi_ctrl.sv
`timescale 1ns/1ps
module tb_epi_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pkt_start = 1'b0;
   logic [6:0] rate = '0;
   logic [7:0] cnt = '0;
   logic       start = 1'b0;
   logic       man_en = 1'b0;
   logic       man_req = 1'b0;
   logic       done_clr = 1'b0;
   logic       irq_en = 1'b0;
   logic       corrupt, done, irq;
   logic       corrupt2, done2, irq2;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   epi_ctrl dut (
      .clk(clk), .rst_n(rst_n), .pkt_start_i(pkt_start), .rate_i(rate),
      .count_i(cnt), .start_i(start), .man_en_i(man_en), .man_req_i(man_req),
      .done_clr_i(done_clr), .irq_en_i(irq_en),
      .corrupt_o(corrupt), .done_o(done), .irq_o(irq));

   // Small configuration: exponent clamped at 1.
   epi_ctrl #(.EXP_MAX(1)) dut2 (
      .clk(clk), .rst_n(rst_n), .pkt_start_i(pkt_start), .rate_i(rate),
      .count_i(cnt), .start_i(start), .man_en_i(man_en), .man_req_i(man_req),
      .done_clr_i(done_clr), .irq_en_i(irq_en),
      .corrupt_o(corrupt2), .done_o(done2), .irq_o(irq2));

   task automatic chk(input string req, input string what, input int act, input int exp_v);
      n_chk++;
      if (act != exp_v) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp_v);
      end
   endtask

   function automatic int per_of(input logic [6:0] r, input int emax);
      int y, p;
      y = int'(r[6:4]);
      if (y > emax) y = emax;
      p = int'(r[3:0]);
      for (int i = 0; i < y; i++) p = p * 10;
      return p;
   endfunction

   task automatic pkt(output logic c1, output logic c2);
      @(negedge clk);
      pkt_start = 1'b1;
      #1;
      c1 = corrupt;
      c2 = corrupt2;
      @(negedge clk);
      pkt_start = 1'b0;
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic clear_done();
      @(negedge clk); done_clr = 1'b1;
      @(negedge clk); done_clr = 1'b0;
   endtask

   task automatic man_edge();
      @(negedge clk); man_req = 1'b1;
      @(negedge clk); man_req = 1'b0;
   endtask

   task automatic expect_pkt(input string req, input string what, input int exp_v);
      logic c1, c2;
      pkt(c1, c2);
      chk(req, what, int'(c1), exp_v);
   endtask

   // Automatic run with expected spacing computed from the rate code.
   task automatic run_auto(input logic [6:0] r, input logic [7:0] c, input int npk,
                           input bit use2, input string req);
      int p1, p2, h1, h2;
      bit a1, a2, e1, e2;
      logic c1, c2;
      clear_done();
      rate = r; cnt = c;
      pulse_start();
      p1 = per_of(r, 6); p2 = per_of(r, 1);
      a1 = (c != 0) && (r[3:0] != 0); a2 = a1;
      h1 = 0; h2 = 0;
      for (int k = 1; k <= npk; k++) begin
         pkt(c1, c2);
         e1 = a1 && (k % p1 == 0);
         chk(req, $sformatf("rate %h pkt %0d", r, k), int'(c1), int'(e1));
         if (e1) begin
            h1++;
            if (c != 8'hFF && h1 == int'(c)) a1 = 1'b0;
         end
         if (use2) begin
            e2 = a2 && (k % p2 == 0);
            chk("R3", $sformatf("clamped rate %h pkt %0d", r, k), int'(c2), int'(e2));
            if (e2) begin
               h2++;
               if (c != 8'hFF && h2 == int'(c)) a2 = 1'b0;
            end
         end
      end
      chk("R6", $sformatf("completion after rate %h count %0d", r, c), int'(done),
          int'(c != 8'hFF && r[3:0] != 0 && h1 == int'(c)));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=hung expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R6", "reset completion flag", int'(done), 0);
      chk("R7", "reset interrupt", int'(irq), 0);
      expect_pkt("R2", "zero rate after reset", 0);

      // R1 spacing sweeps, finite counts (R5)
      run_auto(7'h01, 8'd5, 8, 1'b0, "R1");
      run_auto(7'h0F, 8'd3, 50, 1'b0, "R1");
      run_auto(7'h11, 8'd2, 25, 1'b0, "R1");
      run_auto(7'h23, 8'd1, 310, 1'b0, "R1");
      run_auto(7'h07, 8'd4, 35, 1'b0, "R5");
      // R3 exponent clamp seen on the small configuration
      run_auto(7'h72, 8'hFF, 45, 1'b1, "R3");
      run_auto(7'h62, 8'hFF, 45, 1'b1, "R3");
      // R5 continuous and zero count
      run_auto(7'h05, 8'hFF, 40, 1'b0, "R5");
      run_auto(7'h01, 8'd0, 4, 1'b0, "R5");

      // R7 interrupt gating with flag set from the zero-count run
      #1 chk("R7", "irq with enable 0", int'(irq), 0);
      @(negedge clk); irq_en = 1'b1;
      #1 chk("R7", "irq with enable 1", int'(irq), 1);
      clear_done();
      #1;
      chk("R6", "flag after clear", int'(done), 0);
      chk("R7", "irq after clear", int'(irq), 0);
      // R6 set beats clear in the same cycle
      rate = 7'h01; cnt = 8'd0;
      @(negedge clk); start = 1'b1; done_clr = 1'b1;
      @(negedge clk); start = 1'b0; done_clr = 1'b0;
      #1 chk("R6", "set wins over clear", int'(done), 1);
      irq_en = 1'b0;

      // R2 stop by zero mantissa, R4 restart
      clear_done();
      rate = 7'h03; cnt = 8'hFF;
      pulse_start();
      expect_pkt("R4", "run pkt 1", 0);
      expect_pkt("R4", "run pkt 2", 0);
      @(negedge clk); rate = 7'h30;
      for (int k = 0; k < 3; k++) expect_pkt("R2", "zero mantissa", 0);
      @(negedge clk); rate = 7'h03;
      for (int k = 0; k < 6; k++) expect_pkt("R2", "stopped run stays off", 0);
      chk("R2", "no completion after stop", int'(done), 0);
      pulse_start();
      expect_pkt("R4", "restart pkt 1", 0);
      expect_pkt("R4", "restart pkt 2", 0);
      pulse_start();
      expect_pkt("R4", "re-armed pkt 1", 0);
      expect_pkt("R4", "re-armed pkt 2", 0);
      expect_pkt("R4", "re-armed pkt 3", 1);

      // R8 manual path, automatic off
      @(negedge clk); rate = 7'h00;
      man_en = 1'b1;
      man_edge();
      @(negedge clk); #1 chk("R10", "pending without strobe", int'(corrupt), 0);
      expect_pkt("R8", "manual edge", 1);
      expect_pkt("R8", "manual single use", 0);
      man_edge(); man_edge(); man_edge();
      expect_pkt("R8", "several edges one packet", 1);
      expect_pkt("R8", "several edges consumed", 0);
      @(negedge clk); man_en = 1'b0;
      man_edge();
      expect_pkt("R8", "edge while disabled", 0);
      @(negedge clk); man_req = 1'b1;
      @(negedge clk); man_en = 1'b1;
      @(negedge clk);
      expect_pkt("R8", "held high is no edge", 0);
      @(negedge clk); man_req = 1'b0;

      // R9 manual is additive to automatic
      rate = 7'h03; cnt = 8'hFF;
      pulse_start();
      man_edge();
      expect_pkt("R9", "manual pkt 1", 1);
      expect_pkt("R9", "pkt 2", 0);
      expect_pkt("R9", "auto pkt 3", 1);
      man_edge();
      expect_pkt("R9", "manual pkt 4", 1);
      expect_pkt("R9", "pkt 5", 0);
      man_edge();
      expect_pkt("R9", "coincident pkt 6", 1);
      expect_pkt("R9", "pkt 7", 0);
      expect_pkt("R9", "pkt 8", 0);
      expect_pkt("R9", "auto pkt 9", 1);
      clear_done();
      rate = 7'h02; cnt = 8'd1;
      pulse_start();
      man_edge();
      expect_pkt("R9", "manual before count", 1);
      chk("R9", "manual uses no count", int'(done), 0);
      expect_pkt("R9", "auto after manual", 1);
      chk("R9", "count ends on auto", int'(done), 1);
      expect_pkt("R5", "after finite run", 0);
      @(negedge clk); #1 chk("R10", "idle corrupt", int'(corrupt), 0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule